// File: doc/BRIEF.md
# DMA Transfer Splitter

This block takes the parameters of one channel's block transfer and turns them into a stream of port transactions. Each transaction is a single element access or a burst of several beats of the element width. Software or a channel controller supplies five values with a one-cycle `start` pulse: the start address, an element width code, an element count, the addressing mode, and a maximum burst code. The block then presents one descriptor at a time on a valid/ready interface. Each descriptor carries the byte address, the element width, the beat count and a flag that marks the final transaction.

Bursts are used only where they fit. A burst needs post-increment addressing, a maximum burst greater than one beat, at least a full burst of elements still to move, and an address aligned to the burst's byte size. While the address is not yet aligned at the start of the transfer, single accesses step it forward. Once fewer elements remain than a full burst, the rest go out as single accesses. A one-cycle `done` pulse follows acceptance of the final descriptor.

Top module: `dma_xfer_splitter`

## Requirements
- R1: After reset, `busy`, `desc_valid` and `done` are all low.
- R2: A `start` is taken only when `busy` is low and `elem_count` is non-zero. A `start` while busy, or with a zero count, has no effect on the descriptor stream or on `busy`.
- R3: A burst of B = 2^`max_burst` beats is issued when all of these hold: the mode is post-increment, B > 1, at least B elements remain, and the current address is a multiple of B times the element byte size.
- R4: When the start address is not aligned to the burst byte size, single-element transactions are issued until the address becomes aligned.
- R5: When fewer than B elements remain, each remaining element is issued as its own single-beat transaction.
- R6: In constant-address mode (`addr_incr`=0), every descriptor has one beat and carries the start address.
- R7: `max_burst` codes 0..4 select 1, 2, 4, 8 or 16 beats, and codes 5..7 select 16 beats. Code 0 gives only single accesses.
- R8: In post-increment mode, each descriptor's address equals the previous descriptor's address plus its beat count times the element byte size.
- R9: The beat counts of a transfer sum to `elem_count`, and only the final descriptor has `desc_last` set.
- R10: While `desc_valid` is high and `desc_ready` is low, the descriptor stays valid and unchanged.
- R11: `done` is high for exactly one cycle, in the cycle after the `desc_last` descriptor is accepted. `busy` is low in that same cycle.
- R12: Element width codes 0, 1 and 2 mean 1, 2 and 4 bytes. Code 3 is treated as 4 bytes and is reported as code 2 on `desc_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with the parameters below |
| start_addr | input | ADDR_W | Byte address of the first element |
| elem_size | input | 2 | Element width code (0=8, 1=16, 2/3=32 bits) |
| elem_count | input | CNT_W | Number of elements to move |
| addr_incr | input | 1 | 1 = post-increment, 0 = constant address |
| max_burst | input | 3 | log2 of the largest burst in beats (clamped to 4) |
| busy | output | 1 | Transfer in progress |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_addr | output | ADDR_W | Transaction byte address |
| desc_size | output | 2 | Normalised element width code |
| desc_beats | output | 5 | Beats in this transaction (1, 2, 4, 8 or 16) |
| desc_last | output | 1 | Final transaction of the transfer |
| done | output | 1 | One-cycle pulse after the final descriptor is accepted |

## Verification
The assertions assume that the consumer follows valid/ready rules, and that a transfer's addresses do not wrap past the top of the address space. The burst alignment check relies on the beat count being a power of two. Stimulus keeps start addresses small and counts short, so addresses never wrap. `desc_ready` comes from a pseudo-random stall pattern that never depends on the descriptor contents. Deliberate `start` pulses that must be ignored are sent only while a transfer is running, or with a zero count.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  localparam int BEAT_W     = 5;
  localparam int MB_LOG_MAX = 4;

  function automatic logic [1:0] size_log2(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [2:0] burst_log2(input logic [2:0] code);
    return (code > 3'(MB_LOG_MAX)) ? 3'(MB_LOG_MAX) : code;
  endfunction
endpackage

// File: rtl/xfer_cursor.sv
module xfer_cursor #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              ld_incr,
  input  logic [1:0]        ld_size,
  input  logic [2:0]        ld_mb,
  input  logic              step,
  input  logic [CNT_W-1:0]  step_beats,
  input  logic [ADDR_W-1:0] step_bytes,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_rem,
  output logic              cur_incr,
  output logic [1:0]        cur_size,
  output logic [2:0]        cur_mb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_rem  <= '0;
      cur_incr <= 1'b0;
      cur_size <= '0;
      cur_mb   <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      cur_rem  <= ld_cnt;
      cur_incr <= ld_incr;
      cur_size <= dxs_pkg::size_log2(ld_size);
      cur_mb   <= dxs_pkg::burst_log2(ld_mb);
    end else if (step) begin
      cur_rem <= cur_rem - step_beats;
      if (cur_incr) cur_addr <= cur_addr + step_bytes;
    end
  end

  // R9: a step never takes more elements than remain
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    step && !load |-> cur_rem >= step_beats);
endmodule

// File: rtl/xfer_plan.sv
module xfer_plan #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [CNT_W-1:0]                rem,
  input  logic                            incr,
  input  logic [1:0]                      size_l2,
  input  logic [2:0]                      mb_l2,
  output logic [dxs_pkg::BEAT_W-1:0]      beats,
  output logic [CNT_W-1:0]                beats_cnt,
  output logic [ADDR_W-1:0]               nbytes,
  output logic                            last
);
  localparam int BW = dxs_pkg::BEAT_W;

  logic [BW-1:0]     full_beats;
  logic [ADDR_W-1:0] align_mask;
  logic              aligned;
  logic              enough;
  logic              use_burst;

  always_comb begin
    full_beats = BW'(1) << mb_l2;
    align_mask = (ADDR_W'(1) << (mb_l2 + 3'(size_l2))) - ADDR_W'(1);
    aligned    = (addr & align_mask) == '0;
    enough     = rem >= CNT_W'(full_beats);
    use_burst  = incr && (mb_l2 != 3'd0) && enough && aligned;
    beats      = use_burst ? full_beats : BW'(1);
    beats_cnt  = CNT_W'(beats);
    nbytes     = ADDR_W'(beats) << size_l2;
    last       = (rem == beats_cnt);
  end
endmodule

// File: rtl/desc_stage.sv
module desc_stage #(
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [1:0]                  in_size,
  input  logic [dxs_pkg::BEAT_W-1:0]  in_beats,
  input  logic                        in_last,
  input  logic                        ready,
  output logic                        valid,
  output logic [ADDR_W-1:0]           addr,
  output logic [1:0]                  size,
  output logic [dxs_pkg::BEAT_W-1:0]  beats,
  output logic                        last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      size  <= '0;
      beats <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= in_addr;
      size  <= in_size;
      beats <= in_beats;
      last  <= in_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10: a stalled descriptor holds
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(addr) && $stable(beats) && $stable(last) && $stable(size));
endmodule

// File: rtl/dma_xfer_splitter.sv
module dma_xfer_splitter #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           start_addr,
  input  logic [1:0]                  elem_size,
  input  logic [CNT_W-1:0]            elem_count,
  input  logic                        addr_incr,
  input  logic [2:0]                  max_burst,
  output logic                        busy,
  output logic                        desc_valid,
  input  logic                        desc_ready,
  output logic [ADDR_W-1:0]           desc_addr,
  output logic [1:0]                  desc_size,
  output logic [dxs_pkg::BEAT_W-1:0]  desc_beats,
  output logic                        desc_last,
  output logic                        done
);
  localparam int BW = dxs_pkg::BEAT_W;

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_rem;
  logic              cur_incr;
  logic [1:0]        cur_size;
  logic [2:0]        cur_mb;
  logic [BW-1:0]     pl_beats;
  logic [CNT_W-1:0]  pl_beats_cnt;
  logic [ADDR_W-1:0] pl_bytes;
  logic              pl_last;
  logic              start_ok;
  logic              accept;
  logic              issue;

  assign start_ok = start && !busy && (elem_count != '0);
  assign accept   = desc_valid && desc_ready;
  assign issue    = busy && (cur_rem != '0) && (!desc_valid || desc_ready);

  xfer_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
    .clk(clk), .rst(rst), .load(start_ok),
    .ld_addr(start_addr), .ld_cnt(elem_count), .ld_incr(addr_incr),
    .ld_size(elem_size), .ld_mb(max_burst),
    .step(issue), .step_beats(pl_beats_cnt), .step_bytes(pl_bytes),
    .cur_addr(cur_addr), .cur_rem(cur_rem), .cur_incr(cur_incr),
    .cur_size(cur_size), .cur_mb(cur_mb)
  );

  xfer_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
    .addr(cur_addr), .rem(cur_rem), .incr(cur_incr), .size_l2(cur_size),
    .mb_l2(cur_mb), .beats(pl_beats), .beats_cnt(pl_beats_cnt),
    .nbytes(pl_bytes), .last(pl_last)
  );

  desc_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .load(issue),
    .in_addr(cur_addr), .in_size(cur_size), .in_beats(pl_beats), .in_last(pl_last),
    .ready(desc_ready), .valid(desc_valid), .addr(desc_addr), .size(desc_size),
    .beats(desc_beats), .last(desc_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= accept && desc_last;
      if (start_ok) busy <= 1'b1;
      else if (accept && desc_last) busy <= 1'b0;
    end
  end

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: done only follows acceptance of the final descriptor
  p_done_after_last_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(desc_valid && desc_ready && desc_last) && !busy);
  // R6: constant addressing never bursts
  p_const_single_r6: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !cur_incr |-> desc_beats == BW'(1));
  // R7: beat counts are legal powers of two
  p_beats_legal_r7: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> $onehot(desc_beats) && desc_beats <= BW'(16));
  // R3: every burst starts on its own byte-size boundary
  p_burst_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    desc_valid && desc_beats > BW'(1) |->
      (desc_addr & ((ADDR_W'(desc_beats) << desc_size) - ADDR_W'(1))) == '0);
  // R2: no descriptor outside a transfer
  p_valid_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> busy);
endmodule

// File: tb/dma_xfer_splitter_bench.sv
`timescale 1ns/1ps
module dma_xfer_splitter_bench;
  localparam int AW = 32;
  localparam int CW = 16;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [1:0]    s;
    logic [4:0]    b;
    logic          l;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] elem_size = '0;
  logic [CW-1:0] elem_count = '0;
  logic addr_incr = 1'b0;
  logic [2:0] max_burst = '0;
  logic busy, desc_valid, desc_last, done;
  logic desc_ready = 1'b1;
  logic [AW-1:0] desc_addr;
  logic [1:0] desc_size;
  logic [4:0] desc_beats;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  int done_cnt = 0;

  always #2 clk = ~clk;

  dma_xfer_splitter #(.ADDR_W(AW), .CNT_W(CW)) u_dma_xfer_splitter (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .elem_size(elem_size), .elem_count(elem_count), .addr_incr(addr_incr),
    .max_burst(max_burst), .busy(busy), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_addr(desc_addr), .desc_size(desc_size),
    .desc_beats(desc_beats), .desc_last(desc_last), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready driver: pseudo-random stalls when enabled
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    desc_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  bit prev_stall = 1'b0;
  exp_t prev_d;
  bit last_acc = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(desc_valid && {desc_addr, desc_size, desc_beats, desc_last} == prev_d,
              "R10 stalled descriptor held", {desc_addr, desc_beats}, {prev_d.a, prev_d.b});
      if (last_acc) begin
        check(done == 1'b1, "R11 done after last accept", done, 1);
        check(busy == 1'b0, "R11 busy low with done", busy, 0);
      end else begin
        check(done == 1'b0, "R11 done only after last", done, 0);
      end
      if (done) done_cnt++;
      if (desc_valid && desc_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected descriptor", desc_addr, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(desc_addr == e.a, "R8 descriptor address", desc_addr, e.a);
          check(desc_beats == e.b, "R3 R4 R5 beat count", desc_beats, e.b);
          check(desc_size == e.s, "R12 element size code", desc_size, e.s);
          check(desc_last == e.l, "R9 last flag", desc_last, e.l);
        end
      end
      prev_stall = desc_valid && !desc_ready;
      prev_d = '{a: desc_addr, s: desc_size, b: desc_beats, l: desc_last};
      last_acc = desc_valid && desc_ready && desc_last;
    end
  end

  task automatic push_exp(input logic [AW-1:0] addr, input logic [1:0] sz,
                          input int cnt, input bit incr, input logic [2:0] mb);
    int sl = (sz == 2'd3) ? 2 : int'(sz);
    int ml = (mb > 3'd4) ? 4 : int'(mb);
    int bmax = 1 << ml;
    int eb = 1 << sl;
    longint a = addr;
    int r = cnt;
    while (r > 0) begin
      int bb;
      exp_t e;
      bb = (incr && ml > 0 && r >= bmax && (a % (bmax * eb)) == 0) ? bmax : 1;
      e.a = AW'(a); e.s = 2'(sl); e.b = 5'(bb); e.l = (r == bb);
      q.push_back(e);
      if (incr) a = a + bb * eb;
      r = r - bb;
    end
  endtask

  task automatic run_xfer(input logic [AW-1:0] addr, input logic [1:0] sz, input int cnt,
                          input bit incr, input logic [2:0] mb, input bit poke);
    int base = done_cnt;
    int t = 0;
    push_exp(addr, sz, cnt, incr, mb);
    @(posedge clk); #1;
    start = 1'b1; start_addr = addr; elem_size = sz; elem_count = CW'(cnt);
    addr_incr = incr; max_burst = mb;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (2) @(posedge clk);
      #1; start = 1'b1; start_addr = 32'h500; elem_count = 9; addr_incr = 1'b0;
      @(posedge clk); #1; start = 1'b0;
    end
    while (done_cnt == base && t < 3000) begin
      @(negedge clk); t++;
    end
    check(done_cnt == base + 1, "R9 transfer completed", done_cnt - base, 1);
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9 all expected descriptors seen", q.size(), 0);
    check(busy == 1'b0 && desc_valid == 1'b0, "R2 idle after transfer", busy, 0);
    q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(desc_valid == 0, "R1 valid after reset", desc_valid, 0);
    check(done == 0, "R1 done after reset", done, 0);

    // R4 head singles, R3 bursts, R5 tail singles, 32-bit, 4-beat bursts
    run_xfer(32'h1004, 2'd2, 37, 1'b1, 3'd2, 1'b0);
    // same with stalls (R10) and an ignored start while busy (R2)
    stall_en = 1'b1;
    run_xfer(32'h1004, 2'd2, 37, 1'b1, 3'd2, 1'b1);
    // R6 constant address mode, bytes
    run_xfer(32'h77, 2'd0, 5, 1'b0, 3'd3, 1'b0);
    // R7 code 0: only singles, 16-bit
    run_xfer(32'h40, 2'd1, 4, 1'b1, 3'd0, 1'b0);
    // R7 code 7 clamps to 16 beats; bytes with tail singles
    run_xfer(32'h20, 2'd0, 40, 1'b1, 3'd7, 1'b1);
    stall_en = 1'b0;
    // R12 size code 3 treated as 32-bit
    run_xfer(32'h8, 2'd3, 3, 1'b1, 3'd1, 1'b0);
    // R4 address never aligned to the burst boundary: all singles
    run_xfer(32'h2, 2'd2, 6, 1'b1, 3'd1, 1'b0);
    // R8 16-bit 8-beat bursts from an unaligned start
    run_xfer(32'h106, 2'd1, 30, 1'b1, 3'd3, 1'b0);

    // R2 zero count is ignored
    @(posedge clk); #1;
    start = 1'b1; elem_count = '0; start_addr = 32'h900;
    @(posedge clk); #1; start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(busy == 0 && desc_valid == 0, "R2 zero count ignored", busy, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule